// File: doc/BRIEF.md
# Prescaled UART Baud Tick Generator

This block produces the baud-rate tick that paces a UART's transmit and receive engines. One of two clock sources is selected. Each source is modelled as an enable pulse in a single clock domain. The selected pulses pass through a coded prescaler (divide by 12, 4, 48 or 1). A 16-bit reload counter then divides them further and emits a one-cycle tick each time it wraps.

Software sets the block up through a small byte-wide register bus. Offset 0 is the control byte. Offsets 1 and 2 are the low and high bytes of the reload value. A run bit in the control byte gates the whole generator and is also exported, so the UART engines can stay idle while it is clear. Changes to the prescaler or source made while running never shorten a period. They are picked up only when a new prescaler period begins.

Top module: `baud_tick_gen`

## Requirements
- R1: Control bit 7 selects the source: 0 counts pulses on `sys_en`, 1 counts pulses on `alt_en`; pulses on the unselected input have no effect on the tick output.
- R2: Control bit 6 is the run bit, mirrored on `uart_run`; while it is 0 no tick is issued and both internal counters are held at zero.
- R3: Control bits 1:0 select the prescale ratio: 00 gives 12, 01 gives 4, 10 gives 48, 11 gives 1 source pulse per prescaler output.
- R4: Control bits 5:2 always read 0 and ignore writes; offset 3 reads 0x00 and ignores writes.
- R5: After reset, every register reads 0x00, `uart_run` is low and `baud_tick` is low.
- R6: Offset 1 holds bits 7:0 and offset 2 holds bits 15:8 of the reload value R. `baud_tick` pulses for one cycle once every (R+1) prescaler outputs, so the period is (R+1)*ratio selected source pulses.
- R7: `baud_tick` is registered and rises one cycle after the source pulse that completes a period. After the run bit is set, the first tick follows a full period of (R+1)*ratio pulses counted from the first clock in which `uart_run` is high.
- R8: Prescaler ratio and source are sampled at the first counted pulse of each prescaler period; a write while running leaves the period in progress unchanged.
- R9: When R is lowered below the current reload count, the next prescaler output wraps the counter and issues a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the block and both source enables |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_en | input | 1 | Pulse stream of the system clock source |
| alt_en | input | 1 | Pulse stream of the second clock source |
| reg_addr | input | 2 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| baud_tick | output | 1 | One-cycle baud tick to the UART engines |
| uart_run | output | 1 | Run bit, high while the UART may operate |

## Verification
The bench measures the exact distance to the first tick after enabling, for each prescale code and several reload values. A design that did not clear its counters, or that ran one period with stale settings, would show a short or long first interval. It switches the ratio right after a tick, where a design applying the change at once would cut the running 48-pulse period. It lowers the reload below the live count, where an equality compare would run on for tens of thousands of pulses. It also drives the unselected source alone, which must produce no ticks. A cycle model compares the tick and run outputs on every clock while sources toggle irregularly and settings change.

// File: rtl/baud_pkg.sv
// Package: shared constants and the prescale decode for the baud tick generator.
// Assumes an 8-bit register bus; offsets and bit positions are software-visible.
package baud_pkg;
    localparam int CTRL_OFS   = 0;
    localparam int RELOAD_OFS = 1;
    localparam int SRC_BIT    = 7;
    localparam int RUN_BIT    = 6;
    localparam int PRE_W      = 6;

    // Map the 2-bit prescale code to its ratio in source pulses.
    function automatic logic [PRE_W-1:0] presc_div(input logic [1:0] code);
        case (code)
            2'b00:   presc_div = PRE_W'(12);
            2'b01:   presc_div = PRE_W'(4);
            2'b10:   presc_div = PRE_W'(48);
            default: presc_div = PRE_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/baud_ctrl_regs.sv
// Module: control and reload registers of the baud generator.
// Holds the source, run and prescale fields plus the reload bytes; the
// reserved control bits are not stored. Assumes single-cycle write strobes.
module baud_ctrl_regs
    import baud_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RELOAD_W = 16,
    parameter int ADDR_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                src_sel,
    output logic                run,
    output logic [1:0]          ps_code,
    output logic [RELOAD_W-1:0] reload
);
    localparam int NB = RELOAD_W / DATA_W;

    logic                           src_q;
    logic                           run_q;
    logic [1:0]                     ps_q;
    logic [NB-1:0][DATA_W-1:0]      rl_q;

    // Control byte: capture only the implemented fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            run_q <= 1'b0;
            ps_q  <= 2'b00;
        end else if (reg_we && reg_addr == ADDR_W'(CTRL_OFS)) begin
            src_q <= reg_wdata[SRC_BIT];
            run_q <= reg_wdata[RUN_BIT];
            ps_q  <= reg_wdata[1:0];
        end
    end

    // Reload bytes, least significant at the lowest offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rl_q <= '0;
        end else if (reg_we) begin
            for (int b = 0; b < NB; b++) begin
                if (reg_addr == ADDR_W'(RELOAD_OFS + b))
                    rl_q[b] <= reg_wdata;
            end
        end
    end

    // Read multiplexer; reserved bits and unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(CTRL_OFS)) begin
            reg_rdata[SRC_BIT] = src_q;
            reg_rdata[RUN_BIT] = run_q;
            reg_rdata[1:0]     = ps_q;
        end
        for (int b = 0; b < NB; b++) begin
            if (reg_addr == ADDR_W'(RELOAD_OFS + b))
                reg_rdata = rl_q[b];
        end
    end

    assign src_sel = src_q;
    assign run     = run_q;
    assign ps_code = ps_q;
    assign reload  = rl_q;
endmodule

// File: rtl/baud_prescaler.sv
// Module: source select and coded prescaler.
// Counts pulses of the selected source and flags the pulse that ends a
// prescaler period. Source and ratio come straight from the registers while
// the count is zero and are frozen for the rest of the period, so a change
// never cuts a period short. Assumes both sources are enables in clk's domain.
module baud_prescaler
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       sys_en,
    input  logic       alt_en,
    input  logic       src_sel,
    input  logic [1:0] ps_code,
    output logic       pre_tick
);
    logic [PRE_W-1:0] pcnt;
    logic             src_act;
    logic [PRE_W-1:0] div_act;
    logic             src_eff;
    logic [PRE_W-1:0] div_eff;
    logic             pulse;
    logic             last;

    // Pick live settings at a period boundary, frozen ones inside a period.
    always_comb begin
        src_eff  = (pcnt == '0) ? src_sel : src_act;
        div_eff  = (pcnt == '0) ? presc_div(ps_code) : div_act;
        pulse    = src_eff ? alt_en : sys_en;
        last     = (pcnt == div_eff - PRE_W'(1));
        pre_tick = run && pulse && last;
    end

    // Period counter, cleared while stopped; freezes settings on first pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt    <= '0;
            src_act <= 1'b0;
            div_act <= PRE_W'(1);
        end else if (pulse) begin
            if (last) begin
                pcnt <= '0;
            end else begin
                if (pcnt == '0) begin
                    src_act <= src_eff;
                    div_act <= div_eff;
                end
                pcnt <= pcnt + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/baud_reload_div.sv
// Module: reload divider after the prescaler.
// Counts prescaler outputs and wraps once the count reaches or passes the
// reload value, registering a one-cycle tick. The >= compare bounds the
// period when the reload is lowered mid-count.
module baud_reload_div #(
    parameter int RELOAD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  logic                pre_tick,
    input  logic [RELOAD_W-1:0] reload,
    output logic                baud_tick
);
    logic [RELOAD_W-1:0] dcnt;

    // Reload count and registered tick, both cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt      <= '0;
            baud_tick <= 1'b0;
        end else begin
            baud_tick <= 1'b0;
            if (pre_tick) begin
                if (dcnt >= reload) begin
                    dcnt      <= '0;
                    baud_tick <= 1'b1;
                end else begin
                    dcnt <= dcnt + RELOAD_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Module: top of the prescaled UART baud tick generator.
// Registers feed a source-select prescaler and then a reload divider; the
// run bit is exported to the UART engines. Fully synchronous to clk.
module baud_tick_gen #(
    parameter int DATA_W   = 8,
    parameter int RELOAD_W = 16,
    parameter int ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_en,
    input  logic              alt_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              baud_tick,
    output logic              uart_run
);
    logic                src_sel;
    logic                run;
    logic [1:0]          ps_code;
    logic [RELOAD_W-1:0] reload_w;
    logic                pre_tick;

    baud_ctrl_regs #(
        .DATA_W   (DATA_W),
        .RELOAD_W (RELOAD_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_sel   (src_sel),
        .run       (run),
        .ps_code   (ps_code),
        .reload    (reload_w)
    );

    baud_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sys_en   (sys_en),
        .alt_en   (alt_en),
        .src_sel  (src_sel),
        .ps_code  (ps_code),
        .pre_tick (pre_tick)
    );

    baud_reload_div #(
        .RELOAD_W (RELOAD_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .pre_tick  (pre_tick),
        .reload    (reload_w),
        .baud_tick (baud_tick)
    );

    assign uart_run = run;
endmodule

// File: rtl/baud_tick_gen_chk.sv
// Checker: temporal properties of the baud tick generator, bound to the top.
module baud_tick_gen_chk #(
    parameter int DATA_W   = 8,
    parameter int RELOAD_W = 16,
    parameter int ADDR_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sys_en,
    input logic                alt_en,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_we,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                baud_tick,
    input logic                uart_run,
    input logic                pre_tick,
    input logic [RELOAD_W-1:0] reload_w
);
    // R2: a stopped generator issues no tick in the following cycle.
    a_r2_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_run |=> !baud_tick);

    // R2: prescaler output only while running.
    a_r2_pre_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        pre_tick |-> uart_run);

    // R4: reserved control bits read zero.
    a_r4_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(0)) |-> (reg_rdata[5:2] == 4'b0000));

    // R6: low reload byte takes the written value.
    a_r6_low_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(1)) |=> (reload_w[7:0] == $past(reg_wdata)));

    // R7: each tick follows a source pulse and a prescaler output one cycle earlier.
    a_r7_tick_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(sys_en || alt_en));

    a_r7_tick_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(pre_tick));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(
    .DATA_W   (DATA_W),
    .RELOAD_W (RELOAD_W),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_en    (sys_en),
    .alt_en    (alt_en),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .baud_tick (baud_tick),
    .uart_run  (uart_run),
    .pre_tick  (pre_tick),
    .reload_w  (reload_w)
);

// File: tb/sim_baud_tick_gen.sv
// Bench: directed scenarios plus a behavioural cycle model checked every clock.
module sim_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_en = 1'b1;
    logic       alt_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       baud_tick;
    logic       uart_run;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string phase = "R5";

    baud_tick_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_en    (sys_en),
        .alt_en    (alt_en),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .baud_tick (baud_tick),
        .uart_run  (uart_run)
    );

    always #4 clk = ~clk;

    // Second source: a pulse every other cycle.
    always @(negedge clk) alt_en <= ~alt_en;

    // Behavioural reference state.
    logic [7:0]  m_ctrl = 8'h00;
    int unsigned m_rl = 0;
    int          m_pc = 0;
    int unsigned m_dc = 0;
    int          m_div = 1;
    bit          m_src = 1'b0;
    bit          m_tick = 1'b0;

    function automatic int ratio(input logic [1:0] c);
        case (c)
            2'b00:   return 12;
            2'b01:   return 4;
            2'b10:   return 48;
            default: return 1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model at each edge and compare outputs shortly after.
    always @(posedge clk) begin
        bit s;
        bit e;
        bit pre;
        int d;
        pre = 1'b0;
        if (!rst_n) begin
            m_ctrl = 8'h00; m_rl = 0; m_pc = 0; m_dc = 0; m_tick = 1'b0;
        end else begin
            m_tick = 1'b0;
            if (!m_ctrl[6]) begin
                m_pc = 0; m_dc = 0;
            end else begin
                s = (m_pc == 0) ? m_ctrl[7] : m_src;
                d = (m_pc == 0) ? ratio(m_ctrl[1:0]) : m_div;
                e = s ? alt_en : sys_en;
                if (e) begin
                    if (m_pc == d - 1) begin
                        m_pc = 0; pre = 1'b1;
                    end else begin
                        if (m_pc == 0) begin m_src = s; m_div = d; end
                        m_pc++;
                    end
                end
                if (pre) begin
                    if (m_dc >= m_rl) begin m_dc = 0; m_tick = 1'b1; end
                    else m_dc++;
                end
            end
            if (reg_we) begin
                case (reg_addr)
                    2'd0: m_ctrl = reg_wdata & 8'hC3;
                    2'd1: m_rl = (m_rl & 32'hFF00) | reg_wdata;
                    2'd2: m_rl = (m_rl & 32'h00FF) | (32'(reg_wdata) << 8);
                    default: ;
                endcase
            end
        end
        #2;
        if (!done) begin
            check({phase, " tick"}, int'(baud_tick), int'(m_tick));
            check({phase, " run"}, int'(uart_run), int'(m_ctrl[6]));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #2;
            n++;
            if (baud_tick) return;
        end
        n = -1;
    endtask

    task automatic start(input logic [1:0] ps, input int r, input bit src);
        wr(2'd0, 8'h00);
        wr(2'd1, r[7:0]);
        wr(2'd2, r[15:8]);
        wr(2'd0, {src, 1'b1, 4'b0000, ps});
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #2;
            if (baud_tick) n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset values
        rd(2'd0, 8'h00, "R5 ctrl");
        rd(2'd1, 8'h00, "R5 reload lo");
        rd(2'd2, 8'h00, "R5 reload hi");
        check("R5 tick", int'(baud_tick), 0);
        check("R5 run", int'(uart_run), 0);

        // R4: reserved bits and unmapped offset
        phase = "R4";
        wr(2'd0, 8'h3C);
        rd(2'd0, 8'h00, "R4 reserved only");
        wr(2'd1, 8'h5A);
        wr(2'd3, 8'hA5);
        rd(2'd3, 8'h00, "R4 offset3");
        rd(2'd1, 8'h5A, "R4 offset3 write ignored");
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'hC3, "R4 ctrl readback");
        wr(2'd0, 8'h00);

        // R2: stopped generator stays quiet
        phase = "R2";
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h03);
        count_ticks(100, n);
        check("R2 no ticks while stopped", n, 0);
        check("R2 run low", int'(uart_run), 0);

        // R3 R6 R7: first latency and period per prescale code
        phase = "R3";
        start(2'b00, 2, 1'b0);
        wait_tick(n); check("R7 first tick div12 R2", n, 36);
        wait_tick(n); check("R3 period div12 R2", n, 36);
        start(2'b01, 0, 1'b0);
        wait_tick(n); check("R7 first tick div4 R0", n, 4);
        wait_tick(n); check("R3 period div4 R0", n, 4);
        start(2'b10, 1, 1'b0);
        wait_tick(n); check("R7 first tick div48 R1", n, 96);
        wait_tick(n); check("R3 period div48 R1", n, 96);
        start(2'b11, 5, 1'b0);
        wait_tick(n); check("R7 first tick div1 R5", n, 6);
        wait_tick(n); check("R3 period div1 R5", n, 6);
        phase = "R6";
        start(2'b11, 256, 1'b0);
        wait_tick(n); check("R6 high byte first", n, 257);
        wait_tick(n); check("R6 high byte period", n, 257);

        // R1: second source, and unselected source ignored
        phase = "R1";
        sys_en = 1'b0;
        start(2'b01, 1, 1'b1);
        wait_tick(n);
        wait_tick(n); check("R1 alt source period", n, 16);
        wr(2'd0, 8'h41);
        count_ticks(100, n);
        check("R1 sys source idle no ticks", n, 0);
        sys_en = 1'b1;
        wr(2'd0, 8'hC1);
        count_ticks(100, n);
        check("R1 alt selected ignores sys", n, 6);

        // R8: ratio change mid-period waits for the period boundary
        phase = "R8";
        start(2'b10, 0, 1'b0);
        wait_tick(n); check("R8 first", n, 48);
        wr(2'd0, 8'h41);
        wait_tick(n); check("R8 old period kept", n, 47);
        wait_tick(n); check("R8 new period", n, 4);

        // R9: reload lowered below the live count
        phase = "R9";
        start(2'b11, 9, 1'b0);
        wait_tick(n); check("R9 first", n, 10);
        repeat (4) @(posedge clk);
        wr(2'd1, 8'h02);
        wait_tick(n); check("R9 wrap at next output", n, 1);
        wait_tick(n); check("R9 new period", n, 3);

        // R8: irregular source with settings changes, checked by the model
        phase = "R8 mixed";
        start(2'b00, 1, 1'b0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            sys_en = (i % 3) != 0;
            if (i == 150) begin reg_addr = 2'd0; reg_wdata = 8'h42; reg_we = 1'b1; end
            else if (i == 300) begin reg_addr = 2'd0; reg_wdata = 8'hC3; reg_we = 1'b1; end
            else if (i == 450) begin reg_addr = 2'd0; reg_wdata = 8'h40; reg_we = 1'b1; end
            else reg_we = 1'b0;
        end
        @(negedge clk);
        reg_we = 1'b0;
        wr(2'd0, 8'h00);
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule